// File: doc/BRIEF.md
# Prescaled SCL Clock Generator

This block turns the system clock into the timing of a two-wire serial clock line. A prescaler divides the system clock by a power of two chosen by a 4-bit exponent and produces a base tick. Two small counters then count these ticks: one sets how long the line is held low and one sets how long it is released high. Both phase counts are stored as the tick count minus one, so a stored zero still gives one tick. The single period is therefore `2^exp * ((high+1) + (low+1))` system clocks.

A byte engine next to this block uses `scl_out` as the level request for the clock pin: 0 pulls the line low and 1 releases it. It shifts its data on `change_stb`, which falls in the middle of each low phase, and captures on `sample_stb`, which falls in the middle of each high phase. The generator reads back the real line level on `scl_in`. A target device that holds the line low during the high phase stretches that phase, because the high counters wait until the line is seen high. A new timing word is taken only when a low phase begins, so a period already in progress is never cut short. A parameter narrows the two phase fields from 4 to 3 bits.

Top module: `scl_clkgen`

## Requirements
- R1: After synchronous reset, and while the generator is idle, `scl_out` is 1 and `change_stb` and `sample_stb` are both 0.
- R2: The low phase lasts exactly `2^E * (L+1)` clocks. E is `timing_reg[3:0]` and L is the low field, which starts at bit 12.
- R3: The high phase lasts exactly `2^E * (H+1)` clocks when the line is not stretched. H is the high field, which starts at bit 16.
- R4: A field value of 0 gives one base tick for its phase. With E=0 and both fields 0, the line toggles every clock (period of 2 clocks).
- R5: Bits 31:20 and 11:4 of `timing_reg` have no effect on the waveform or on the strobes.
- R6: With `FIELD_W`=3, the high field is bits 18:16 and the low field is bits 14:12. Bits 19 and 15 are ignored, and each phase lasts at most 8 ticks.
- R7: A new value on `timing_reg` takes effect only at the start of the next low phase. The phase in progress, and the high phase after it, keep the old timing.
- R8: While `scl_in` reads 0 during the high phase, the high-phase count holds. Each stretched clock adds one clock to the high phase.
- R9: `change_stb` pulses for exactly one clock per low phase. The pulse falls at clock offset `(L>>1) * 2^E` from the start of that phase.
- R10: `sample_stb` pulses for exactly one clock per high phase, only while `scl_in` is 1. The pulse falls after `(H>>1) * 2^E` unstretched clocks of that phase.
- R11: When `enable` is 1 in idle, a low phase starts at the next clock edge. When `enable` drops, the generator finishes the current low and high phases and then stays idle with `scl_out` at 1.
- R12: Exponent values up to 15 are honoured exactly (a base tick of 32768 clocks).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; stopping waits for the end of a high phase |
| timing_reg | input | REG_W | Timing word: exponent in 3:0, low field at 12, high field at 16 |
| scl_in | input | 1 | Clock line level, already synchronized to `clk` |
| scl_out | output | 1 | Clock level request (0 = pull low, 1 = release) |
| change_stb | output | 1 | One-clock pulse in the middle of the low phase |
| sample_stb | output | 1 | One-clock pulse in the middle of the high phase |

## Verification
Most wrong internal states show up as a wrong phase length. A bad prescaler wrap or a phase count off by one makes a low or high phase longer or shorter. That error appears at `scl_out` at the end of the first phase after the fault. A wrong decode of the midpoint moves or duplicates a strobe inside that same phase. Configuration taken at the wrong moment cannot be seen until the following period, so the tests change the timing word in the middle of a phase. Stretching faults appear only while the line is held low, so the bench holds the line low at the start of a high phase and measures both the phase length and the sample position.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Generator phase; the encoding has no external meaning.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Bit positions inside the timing word that the bus software programs.
  localparam int EXP_LSB  = 0;
  localparam int EXP_W    = 4;
  localparam int LOW_LSB  = 12;
  localparam int HIGH_LSB = 16;

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [REG_W-1:0]   timing_reg,
  output logic [EXP_W-1:0]   exp_q,
  output logic [FIELD_W-1:0] high_q,
  output logic [FIELD_W-1:0] low_q
);

  logic [EXP_W-1:0]   exp_dec;
  logic [FIELD_W-1:0] high_dec;
  logic [FIELD_W-1:0] low_dec;
  logic               unused_reg_bits;

  assign exp_dec = timing_reg[EXP_LSB +: EXP_W];

  // The narrow variant drops the top bit of each phase field.
  generate
    if (FIELD_W >= 4) begin : g_wide
      assign high_dec = timing_reg[HIGH_LSB +: FIELD_W];
      assign low_dec  = timing_reg[LOW_LSB  +: FIELD_W];
    end else begin : g_narrow
      assign high_dec = timing_reg[HIGH_LSB +: FIELD_W];
      assign low_dec  = timing_reg[LOW_LSB  +: FIELD_W];
    end
  endgenerate

  // Hold/setup fields and reserved bits are not used by this generator.
  assign unused_reg_bits = ^timing_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (load) begin
      exp_q  <= exp_dec;
      high_q <= high_dec;
      low_q  <= low_dec;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_gen_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             adv,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick,
  output logic             at_zero
);

  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  // Base tick period is 2^exp clocks; the counter wraps at 2^exp - 1.
  always_comb begin
    limit   = PRE_W'((64'd1 << exp_i) - 64'd1);
    tick    = (cnt_q == limit);
    at_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (adv) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + ONE;
    end
  end

  assert_pre_range_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               scl_in,
  input  logic               tick,
  input  logic               pre_zero,
  input  logic [FIELD_W-1:0] high_i,
  input  logic [FIELD_W-1:0] low_i,
  output phase_e             state_o,
  output logic               load_o,
  output logic               adv_o,
  output logic               clear_o,
  output logic               scl_o,
  output logic               change_stb,
  output logic               sample_stb
);

  localparam logic [FIELD_W-1:0] PH_ONE = FIELD_W'(1);

  phase_e             st_q, st_d;
  logic [FIELD_W-1:0] ph_q, ph_d;
  logic               run_high;
  logic               end_low;
  logic               end_high;
  logic               scl_q;

  always_comb begin
    run_high = (st_q == PH_HIGH) && scl_in;
    adv_o    = (st_q == PH_LOW) || run_high;
    clear_o  = (st_q == PH_IDLE);
    end_low  = (st_q == PH_LOW) && tick && (ph_q == low_i);
    end_high = run_high && tick && (ph_q == high_i);
    st_d     = st_q;
    ph_d     = ph_q;
    case (st_q)
      PH_IDLE: begin
        if (enable) st_d = PH_LOW;
      end
      PH_LOW: begin
        if (end_low) begin
          st_d = PH_HIGH;
          ph_d = '0;
        end else if (tick) begin
          ph_d = ph_q + PH_ONE;
        end
      end
      PH_HIGH: begin
        if (end_high) begin
          st_d = enable ? PH_LOW : PH_IDLE;
          ph_d = '0;
        end else if (run_high && tick) begin
          ph_d = ph_q + PH_ONE;
        end
      end
      default: begin
        st_d = PH_IDLE;
        ph_d = '0;
      end
    endcase
    load_o = ((st_q == PH_IDLE) && enable) || (end_high && enable);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_IDLE;
      ph_q  <= '0;
      scl_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      scl_q <= (st_d != PH_LOW);
    end
  end

  assign state_o    = st_q;
  assign scl_o      = scl_q;
  assign change_stb = (st_q == PH_LOW) && pre_zero && (ph_q == (low_i >> 1));
  assign sample_stb = run_high && pre_zero && (ph_q == (high_i >> 1));

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_IDLE) |-> scl_q);

  assert_low_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_LOW) |-> (ph_q <= low_i));

  assert_high_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_HIGH) |-> (ph_q <= high_i));

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PH_HIGH) && !scl_in) |=> ((st_q == PH_HIGH) && $stable(ph_q)));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({change_stb, sample_stb}) && (change_stb -> !scl_q));

  assert_sample_high_R10: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (scl_q && scl_in));

  assert_stop_clean_R11: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PH_HIGH) && !enable) |=> (st_q != PH_LOW));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_gen_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int PRE_W   = 16,
  parameter int REG_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [REG_W-1:0] timing_reg,
  input  logic             scl_in,
  output logic             scl_out,
  output logic             change_stb,
  output logic             sample_stb
);

  logic [EXP_W-1:0]   exp_q;
  logic [FIELD_W-1:0] high_q;
  logic [FIELD_W-1:0] low_q;
  logic               load;
  logic               adv;
  logic               clear;
  logic               tick;
  logic               pre_zero;
  phase_e             state;

  scl_cfg_latch #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .timing_reg (timing_reg),
    .exp_q      (exp_q),
    .high_q     (high_q),
    .low_q      (low_q)
  );

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .adv     (adv),
    .exp_i   (exp_q),
    .tick    (tick),
    .at_zero (pre_zero)
  );

  scl_phase_ctrl #(.FIELD_W(FIELD_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .scl_in     (scl_in),
    .tick       (tick),
    .pre_zero   (pre_zero),
    .high_i     (high_q),
    .low_i      (low_q),
    .state_o    (state),
    .load_o     (load),
    .adv_o      (adv),
    .clear_o    (clear),
    .scl_o      (scl_out),
    .change_stb (change_stb),
    .sample_stb (sample_stb)
  );

  // Latched timing may only move on the first clock of a low phase.
  assert_cfg_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable({exp_q, high_q, low_q}) |-> ((state == PH_LOW) && ($past(state) != PH_LOW)));

endmodule

// File: tb/scl_clkgen_tb.sv
`timescale 1ns/1ps
module scl_clkgen_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [31:0] treg;
  logic        stretch;
  logic        scl_in;
  logic        scl_out, change_stb, sample_stb;

  logic        en_n;
  logic [31:0] treg_n;
  logic        scl_out_n, change_n, sample_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  // Wired-AND line: a stretching target pulls it low.
  assign scl_in = scl_out & ~stretch;

  scl_clkgen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .timing_reg(treg),
    .scl_in(scl_in), .scl_out(scl_out), .change_stb(change_stb), .sample_stb(sample_stb)
  );

  scl_clkgen #(.FIELD_W(3)) u_dut_n (
    .clk(clk), .rst(rst), .enable(en_n), .timing_reg(treg_n),
    .scl_in(scl_out_n), .scl_out(scl_out_n), .change_stb(change_n), .sample_stb(sample_n)
  );

  // Vector table: timing word, low clocks, high clocks, change offset, sample offset.
  localparam int NV = 8;
  localparam logic [31:0] V_REG [NV] = '{
    32'h0000_0000,  // R4: minimum period, two clocks
    32'h0003_2001,  // R2 R3: exp 1
    32'h000F_F000,  // R3: widest fields
    32'h0005_A002,  // R2 R9: exp 2, unequal phases
    32'hFFF1_4FF3,  // R5: ignored bits set
    32'h0007_0004,  // R10: sample deep in high phase
    32'h000C_3000,  // R9 R10: exp 0
    32'h0000_000F   // R12: largest exponent
  };
  localparam int V_LO [NV] = '{1, 6, 16, 44, 40, 16, 4, 32768};
  localparam int V_HI [NV] = '{1, 8, 16, 24, 16, 128, 13, 32768};
  localparam int V_CH [NV] = '{0, 2, 7, 20, 16, 0, 1, 0};
  localparam int V_SA [NV] = '{0, 2, 7, 8, 0, 48, 6, 0};

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_low_start();
    logic prev;
    prev = scl_out;
    forever begin
      @(negedge clk);
      if (prev && !scl_out) break;
      prev = scl_out;
    end
  endtask

  // Entered on the first low clock; returns on the first low clock of the next period.
  task automatic measure(output int lo, output int hi, output int cidx, output int sidx);
    int nc, ns;
    lo = 0; hi = 0; cidx = -1; sidx = -1; nc = 0; ns = 0;
    while (!scl_out) begin
      if (change_stb) begin cidx = lo; nc++; end
      if (sample_stb) ns++;
      lo++;
      @(negedge clk);
    end
    while (scl_out) begin
      if (sample_stb) begin sidx = hi; ns++; end
      if (change_stb) nc++;
      hi++;
      @(negedge clk);
    end
    if (nc != 1) cidx = -2;
    if (ns != 1) sidx = -2;
  endtask

  task automatic narrow_period(input logic [31:0] val, output int lo, output int hi);
    logic prev;
    treg_n = val;
    en_n = 1'b1;
    prev = scl_out_n;
    forever begin
      @(negedge clk);
      if (prev && !scl_out_n) break;
      prev = scl_out_n;
    end
    lo = 0; hi = 0;
    while (!scl_out_n) begin lo++; @(negedge clk); end
    while (scl_out_n) begin hi++; @(negedge clk); end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lo, hi, ci, si, cnt;
    rst = 1'b1; enable = 1'b0; treg = '0; stretch = 1'b0;
    en_n = 1'b0; treg_n = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 scl_out after reset", int'(scl_out), 1);
    check("R1 change_stb after reset", int'(change_stb), 0);
    check("R1 sample_stb after reset", int'(sample_stb), 0);
    // R11: stays idle without enable
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (scl_out && !change_stb && !sample_stb) cnt++;
    end
    check("R11 idle while disabled", cnt, 10);

    // Table walk
    enable = 1'b1;
    for (int v = 0; v < NV; v++) begin
      treg = V_REG[v];
      wait_low_start();
      measure(lo, hi, ci, si);
      check($sformatf("R2 low length vec%0d", v), lo, V_LO[v]);
      check($sformatf("R3 high length vec%0d", v), hi, V_HI[v]);
      check($sformatf("R9 change offset vec%0d", v), ci, V_CH[v]);
      check($sformatf("R10 sample offset vec%0d", v), si, V_SA[v]);
    end

    // R7: change the timing word two clocks into a low phase
    treg = 32'h0003_2001;
    wait_low_start();
    @(negedge clk);
    @(negedge clk);
    treg = 32'h0000_0000;
    lo = 2;
    while (!scl_out) begin lo++; @(negedge clk); end
    hi = 0;
    while (scl_out) begin hi++; @(negedge clk); end
    check("R7 low keeps old timing", lo, 6);
    check("R7 high keeps old timing", hi, 8);
    lo = 0;
    while (!scl_out) begin lo++; @(negedge clk); end
    check("R7 next low uses new timing", lo, 1);

    // R8: stretch five clocks at the start of the high phase
    treg = 32'h0003_2001;
    wait_low_start();
    while (!scl_out) @(negedge clk);
    stretch = 1'b1;
    hi = 0; si = -1;
    for (int i = 0; i < 5; i++) begin
      if (sample_stb) si = hi;
      hi++;
      @(negedge clk);
    end
    stretch = 1'b0;
    while (scl_out) begin
      if (sample_stb) si = hi;
      hi++;
      @(negedge clk);
    end
    check("R8 stretched high length", hi, 13);
    check("R10 sample after stretch", si, 7);

    // R11: drop enable early in a low phase
    wait_low_start();
    enable = 1'b0;
    lo = 1;
    @(negedge clk);
    while (!scl_out) begin lo++; @(negedge clk); end
    check("R11 low completes after disable", lo, 6);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (scl_out) cnt++;
      @(negedge clk);
    end
    check("R11 line stays high when stopped", cnt, 40);
    enable = 1'b1;
    @(negedge clk);
    check("R11 restart pulls low next edge", int'(scl_out), 0);

    // R6: narrow field variant
    narrow_period(32'h000F_F000, lo, hi);
    check("R6 narrow low length", lo, 8);
    check("R6 narrow high length", hi, 8);
    narrow_period(32'h0008_8000, lo, hi);
    check("R6 narrow ignores bit 15", lo, 1);
    check("R6 narrow ignores bit 19", hi, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule